// File: doc/BRIEF.md
# CAN CRC-15 Checksum Unit

This block computes the 15-bit checksum that protects a CAN frame. It works on one destuffed bit at a time: the frame logic in front of it removes stuff bits and offers only the bits that count toward the checksum. Those bits enter the block on a one-bit valid/ready stream. A clear pulse at the start of each frame empties the checksum register.

In transmit mode the frame logic feeds the frame up to the end of the data field and then pulses `tx_start`. The block copies the checksum into an output shifter and sends it as a second valid/ready stream, most significant bit first. `out_last` marks the fifteenth bit. In receive mode the frame logic also feeds the 15 received checksum bits through the same register and then pulses `rx_end`. One cycle later the block pulses `chk_done` and sets `crc_error` if the register is not zero. The fault-confinement logic reads that single flag.

Back-pressure works the usual way. A stream beat transfers only on a cycle where valid and ready are both high. `in_ready` is low while the checksum is being sent and on any cycle where `tx_start` or `rx_end` is high. While `out_ready` is low, the output holds `out_valid` and `out_bit` unchanged.

Top module: `crc15_unit`

## Requirements
- R1: After `rst` or `clr` the checksum register is zero, `out_valid`, `crc_error` and `chk_done` are 0 and `in_ready` is 1.
- R2: Each accepted input bit d updates the register c (15 bits, bit 14 the MSB) to `{c[13:0],0} ^ ((d ^ c[14]) ? 0x4599 : 0)`. This is the polynomial x^15+x^14+x^10+x^8+x^7+x^4+x^3+1.
- R3: A cycle with `in_valid` low, or with `in_valid` high and `in_ready` low, leaves the register unchanged.
- R4: In transmit mode (`mode_rx`=0), a `tx_start` pulse sends the register as 15 output beats, bit 14 first. `out_last` is high on the fifteenth beat only, and `out_valid` falls after that beat.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_bit` unchanged.
- R6: `in_ready` is low while `out_valid` is high and on any cycle where `tx_start` or `rx_end` is high.
- R7: In receive mode (`mode_rx`=1), an `rx_end` pulse makes `chk_done` high for exactly the next cycle, with `crc_error` = (register != 0). A frame followed by its correct checksum gives 0, and any single corrupted bit gives 1. `crc_error` then holds until `clr` or `rst`.
- R8: `tx_start` has no effect in receive mode, and `rx_end` has no effect in transmit mode.
- R9: `clr` in the middle of a frame discards every bit accepted before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start-of-frame clear, active high |
| mode_rx | input | 1 | 0 = transmit, 1 = receive |
| in_valid | input | 1 | Destuffed input bit is valid |
| in_ready | output | 1 | Block accepts an input bit |
| in_bit | input | 1 | Destuffed frame bit |
| tx_start | input | 1 | Begin checksum shift-out (transmit mode) |
| rx_end | input | 1 | Received checksum field complete (receive mode) |
| out_valid | output | 1 | Checksum output bit is valid |
| out_ready | input | 1 | Consumer takes the checksum bit |
| out_bit | output | 1 | Checksum bit, MSB first |
| out_last | output | 1 | Fifteenth checksum bit |
| chk_done | output | 1 | One-cycle pulse: receive verdict is valid |
| crc_error | output | 1 | Received checksum mismatch |

## Verification
The bench builds the block with its default width of 15 and feedback mask 0x4599. Every shift-out therefore runs the full fifteen beats, and the model can be compared bit for bit with the CAN checksum on frames of random length. Random stalls on both streams reach the hold-under-back-pressure cases, and input offered during a shift-out reaches the refused-beat case. Receive frames with one flipped bit, either in the data or in the checksum field, show that the zero-remainder test catches every single-bit error at this width.

// File: rtl/crc15_pkg.sv
package crc15_pkg;
  localparam int unsigned CRC_W    = 15;
  localparam logic [14:0] CAN_POLY = 15'h4599;

  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc15_lfsr.sv
module crc15_lfsr #(
  parameter int unsigned W = 15,
  parameter logic [W-1:0] POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic         fb;
  logic [W-1:0] crc_next;

  always_comb begin
    fb       = din ^ crc_q[W-1];
    crc_next = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= '0;
    else if (step)   crc_q <= crc_next;
  end
endmodule

// File: rtl/crc15_serializer.sv
module crc15_serializer #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         out_ready,
  output logic         busy,
  output logic         out_bit,
  output logic         out_last
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy  <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (load) begin
        busy  <= 1'b1;
        sh_q  <= load_val;
        cnt_q <= '0;
      end
    end else if (out_ready) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
      if (cnt_q == LAST_IDX) busy  <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign out_bit  = sh_q[W-1];
  assign out_last = busy && (cnt_q == LAST_IDX);
endmodule

// File: rtl/crc15_verdict.sv
module crc15_verdict #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         judge,
  input  logic [W-1:0] crc_q,
  output logic         chk_done,
  output logic         crc_error
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chk_done  <= 1'b0;
      crc_error <= 1'b0;
    end else begin
      chk_done <= judge;
      if (judge) crc_error <= |crc_q;
    end
  end
endmodule

// File: rtl/crc15_unit.sv
module crc15_unit
  import crc15_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CAN_POLY
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic mode_rx,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic tx_start,
  input  logic rx_end,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last,
  output logic chk_done,
  output logic crc_error
);
  crc_mode_e    mode;
  logic         busy;
  logic         step;
  logic         tx_go;
  logic         judge;
  logic [W-1:0] crc_q;

  always_comb begin
    mode     = crc_mode_e'(mode_rx);
    in_ready = !busy && !tx_start && !rx_end;
    step     = in_valid && in_ready;
    tx_go    = tx_start && (mode == MODE_TX);
    judge    = rx_end && (mode == MODE_RX);
  end

  crc15_lfsr #(.W(W), .POLY(POLY)) lfsr_i (
    .clk(clk), .rst(rst), .clr(clr), .step(step), .din(in_bit), .crc_q(crc_q)
  );

  crc15_serializer #(.W(W)) ser_i (
    .clk(clk), .rst(rst), .clr(clr), .load(tx_go), .load_val(crc_q),
    .out_ready(out_ready), .busy(busy), .out_bit(out_bit), .out_last(out_last)
  );

  crc15_verdict #(.W(W)) ver_i (
    .clk(clk), .rst(rst), .clr(clr), .judge(judge), .crc_q(crc_q),
    .chk_done(chk_done), .crc_error(crc_error)
  );

  assign out_valid = busy;
endmodule

// File: rtl/crc15_unit_chk.sv
module crc15_unit_chk (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic mode_rx,
  input logic in_ready,
  input logic tx_start,
  input logic rx_end,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic out_last,
  input logic chk_done,
  input logic crc_error
);
  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_valid && !crc_error && !chk_done && in_ready));

  // R4
  last_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (out_last && out_ready && !clr) |=> !out_valid);

  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_bit)));

  // R6
  ready_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid || tx_start || rx_end) |-> !in_ready);

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(rx_end && mode_rx && !clr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && !(rx_end && mode_rx)) |=> !chk_done);

  // R8
  rx_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_rx && !out_valid) |=> !out_valid);
endmodule

bind crc15_unit crc15_unit_chk chk_i (
  .clk(clk), .rst(rst), .clr(clr), .mode_rx(mode_rx), .in_ready(in_ready),
  .tx_start(tx_start), .rx_end(rx_end), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last),
  .chk_done(chk_done), .crc_error(crc_error)
);

// File: tb/crc15_unit_tb_top.sv
module crc15_unit_tb_top;
  logic clk = 1'b0;
  logic rst, clr, mode_rx, in_valid, in_bit, tx_start, rx_end, out_ready;
  logic in_ready, out_valid, out_bit, out_last, chk_done, crc_error;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  crc15_unit dut_i (
    .clk(clk), .rst(rst), .clr(clr), .mode_rx(mode_rx), .in_valid(in_valid),
    .in_ready(in_ready), .in_bit(in_bit), .tx_start(tx_start), .rx_end(rx_end),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last), .chk_done(chk_done), .crc_error(crc_error)
  );

  function automatic logic [14:0] crc_step(logic [14:0] c, logic d);
    return {c[13:0], 1'b0} ^ ((d ^ c[14]) ? 15'h4599 : 15'h0);
  endfunction

  function automatic logic [14:0] crc_of(logic [255:0] f, int len);
    logic [14:0] c = '0;
    for (int i = 0; i < len; i++) c = crc_step(c, f[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic feed(input logic [255:0] f, input int len);
    for (int i = 0; i < len; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0; in_bit = $urandom_range(0, 1);
      end
      @(negedge clk); in_valid = 1'b1; in_bit = f[i];
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  // Pull 15 beats with random stalls, offering noise input during shift-out.
  task automatic pull(output logic [14:0] got, output int last_at);
    int n = 0;
    int guard = 0;
    bit stalled = 0;
    logic prev = 0;
    got = '0; last_at = -1;
    while (n < 15 && guard < 3000) begin
      @(negedge clk);
      if (stalled) begin
        // R5
        check(out_valid && out_bit == prev, "R5", {out_valid, out_bit}, {1'b1, prev});
      end
      out_ready = $urandom_range(0, 1);
      in_valid  = $urandom_range(0, 1);
      in_bit    = $urandom_range(0, 1);
      #1;
      if (out_valid) check(!in_ready, "R6", in_ready, 0);
      stalled = out_valid && !out_ready;
      prev = out_bit;
      if (out_valid && out_ready) begin
        got = {got[13:0], out_bit};
        if (out_last) last_at = (last_at < 0) ? n : 99;
        n++;
      end
      guard++;
    end
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b0;
    // R4: stream closes after the fifteenth beat
    check(!out_valid, "R4", out_valid, 0);
  endtask

  task automatic tx_run(input logic [14:0] exp, input string req);
    logic [14:0] got;
    int last_at;
    @(negedge clk); tx_start = 1'b1;
    #1 check(!in_ready, "R6", in_ready, 0);
    @(negedge clk); tx_start = 1'b0;
    pull(got, last_at);
    check(got == exp, req, got, exp);
    check(last_at == 14, "R4", last_at, 14);
  endtask

  task automatic rx_run(input logic [255:0] f, input int len, input logic exp_err);
    @(negedge clk); rx_end = 1'b1;
    #1 check(!in_ready, "R6", in_ready, 0);
    @(negedge clk); rx_end = 1'b0;
    check(chk_done == 1'b1, "R7", chk_done, 1);
    check(crc_error == exp_err, "R7", crc_error, exp_err);
    @(negedge clk);
    check(chk_done == 1'b0, "R7", chk_done, 0);
    check(crc_error == exp_err, "R7", crc_error, exp_err);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] f;
    logic [14:0]  c;
    int len;
    void'($urandom(32'd1234));
    rst = 1'b1; clr = 1'b0; mode_rx = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    tx_start = 1'b0; rx_end = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(!out_valid && !crc_error && !chk_done && in_ready, "R1",
          {out_valid, crc_error, chk_done, in_ready}, 4'b0001);
    // R1: register is zero after reset
    tx_run(15'h0, "R1");

    // R2: single 1 bit gives the mask itself
    pulse_clr(); f = '0; f[0] = 1'b1; feed(f, 1);
    tx_run(15'h4599, "R2");

    // R3: input offered during the previous shift-out was refused; same result again
    tx_run(15'h4599, "R3");

    // R8: tx_start in receive mode does nothing
    @(negedge clk); mode_rx = 1'b1; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R8", out_valid, 0);
    // R8: rx_end in transmit mode does nothing
    mode_rx = 1'b0; rx_end = 1'b1;
    @(negedge clk); rx_end = 1'b0;
    @(negedge clk);
    check(!chk_done && !crc_error, "R8", {chk_done, crc_error}, 0);

    // Random transmit frames, some with junk before a mid-frame clear
    for (int k = 0; k < 40; k++) begin
      f = {$urandom(), $urandom(), $urandom(), $urandom(),
           $urandom(), $urandom(), $urandom(), $urandom()};
      len = $urandom_range(1, 200);
      mode_rx = 1'b0;
      if (k % 3 == 0) feed(~f, $urandom_range(1, 30));
      pulse_clr();
      if (k % 3 == 0) begin
        // R9: junk before clr is gone
        check(!crc_error && in_ready, "R9", {crc_error, in_ready}, 2'b01);
      end
      feed(f, len);
      tx_run(crc_of(f, len), (k % 3 == 0) ? "R9" : "R2");
    end

    // Random receive frames: correct, corrupted data, corrupted checksum
    for (int k = 0; k < 45; k++) begin
      int pos;
      f = {$urandom(), $urandom(), $urandom(), $urandom(),
           $urandom(), $urandom(), $urandom(), $urandom()};
      len = $urandom_range(1, 200);
      c = crc_of(f, len);
      for (int i = 0; i < 15; i++) f[len + i] = c[14 - i];
      pos = $urandom_range(0, len + 14);
      if (k % 3 == 1) f[pos] = ~f[pos];
      if (k % 3 == 2) f[len + (pos % 15)] = ~f[len + (pos % 15)];
      @(negedge clk); mode_rx = 1'b1;
      pulse_clr();
      feed(f, len + 15);
      rx_run(f, len + 15, (k % 3) != 0);
    end

    // R1: clr drops a held error flag
    pulse_clr();
    check(!crc_error && !chk_done, "R1", {crc_error, chk_done}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule